// File: doc/BRIEF.md
# Port-Driven IDE Register Strobe Bridge

This block sits between a host that owns an 8-bit bidirectional data port, a single select line and a one-cycle active-low handshake strobe, and the register interface of an IDE or CompactFlash device. The host parks select high and places a control byte on the port. When select falls, that byte is captured. The byte fixes the device register address and which of the read and write strobes may fire. After that, every handshake pulse issued while select stays low turns into exactly one device read or write strobe.

A write burst consists of one command byte followed by any number of data bytes, each with its own handshake pulse. A read burst starts with a dummy access. Each later access returns the byte fetched by the access before it. The last byte is collected after select has been raised again.

The three upper bits of the control byte have no role in the transfers. They are brought out as spare outputs, for example to act as a select for another serial device.

All device-side signals leave the block from flip-flops, one clock after the host inputs that cause them. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pport_ide_bridge`

## Requirements
- R1: While reset is held, and after it is released until select falls, `ide_rd_n_o`, `ide_wr_n_o` and `ide_cs0_n_o` are 1, `ide_addr_o` is 3'b111, `spare_o` is 3'b111 and `host_rdata_o` is 0.
- R2: On a clock where select is sampled low after being high, the control byte on `host_wdata_i` is captured. Bits [2:0] become `ide_addr_o`, bit 3 low enables reads, bit 4 low enables writes, and bits [7:5] become `spare_o`. The captured values are visible one clock later.
- R3: While select stays low, changes on `host_wdata_i` do not alter the captured address, enables or spare bits.
- R4: `ide_cs0_n_o` equals the value that `sel_i` had one clock earlier.
- R5: With select low and writes enabled, a handshake pulse drives `ide_wr_n_o` low for exactly the following clock. During that clock, `ide_data_o` holds the port byte that was present with the pulse and `ide_data_oe_o` is 1.
- R6: With select low and reads enabled, a handshake pulse drives `ide_rd_n_o` low for exactly the following clock. A strobe whose enable bit is 1 never goes low.
- R7: While select is high, neither strobe goes low, whatever the handshake does.
- R8: On the clock where `ide_rd_n_o` returns high, `ide_data_i` is copied into a holding register shown on `host_rdata_o`, including when select rises in that same cycle. At all other times `host_rdata_o` is unchanged.
- R9: Repeated handshake pulses within one select-low period each produce one strobe, all at the same captured address.
- R10: A handshake pulse that arrives in the same cycle as the falling edge of select is gated by the newly captured byte, not by the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Host select; high = command phase, low = device selected |
| hs_n_i | input | 1 | Host handshake strobe, active low, one cycle per access |
| host_wdata_i | input | 8 | Byte driven by the host on its data port |
| host_rdata_o | output | 8 | Read holding register returned to the host |
| ide_cs0_n_o | output | 1 | Device chip select, active low |
| ide_addr_o | output | 3 | Device register address |
| ide_rd_n_o | output | 1 | Device read strobe, active low |
| ide_wr_n_o | output | 1 | Device write strobe, active low |
| ide_data_o | output | 8 | Data driven toward the device |
| ide_data_oe_o | output | 1 | Drive enable for `ide_data_o` |
| ide_data_i | input | 8 | Data returned by the device |
| spare_o | output | 3 | Upper control-byte bits, general purpose |

## Verification
Two functions can land in the same cycle. In the first case, a command capture and a first strobe coincide: the bench lowers select and pulses the handshake on one edge, for both a write command and a read command. The scoreboard then requires a strobe whose address and data come from the byte just captured. In the second case, the holding-register capture and the end of the select period coincide: the final read of a burst releases the handshake in the very cycle that select rises. The bench then requires the holding register to contain the device byte of that last access.

// File: rtl/pport_bridge_pkg.sv
package pport_bridge_pkg;

  localparam int unsigned PORT_W     = 8;
  localparam int unsigned REG_ADDR_W = 3;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } ide_ctl_t;

endpackage

// File: rtl/cmd_latch.sv
module cmd_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] port_i,
  output logic [DATA_W-1:0] cmd_next_o,
  output logic [DATA_W-1:0] cmd_q_o
);

  logic              sel_d_q;
  logic              sel_fall;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] cmd_d;

  assign sel_fall = sel_d_q & ~sel_i;

  always_comb begin
    cmd_d = cmd_q;
    if (sel_fall) begin
      cmd_d = port_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d_q <= 1'b1;
      cmd_q   <= '1;
    end else begin
      sel_d_q <= sel_i;
      cmd_q   <= cmd_d;
    end
  end

  assign cmd_next_o = cmd_d;
  assign cmd_q_o    = cmd_q;

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import pport_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              hs_n_i,
  input  logic              rd_dis_i,
  input  logic              wr_dis_i,
  input  logic [DATA_W-1:0] port_i,
  output ide_ctl_t          ctl_q_o,
  output logic              rd_n_next_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              drive_q_o
);

  ide_ctl_t          ctl_q;
  ide_ctl_t          ctl_d;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] wdata_d;
  logic              drive_q;
  logic              drive_d;
  logic              wdata_en;

  always_comb begin
    ctl_d.cs_n = sel_i;
    ctl_d.rd_n = hs_n_i | sel_i | rd_dis_i;
    ctl_d.wr_n = hs_n_i | sel_i | wr_dis_i;
    drive_d    = ~sel_i & ~wr_dis_i;
    wdata_en   = ~hs_n_i;
    wdata_d    = wdata_en ? port_i : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '1;
      drive_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      drive_q <= drive_d;
      wdata_q <= wdata_d;
    end
  end

  assign ctl_q_o     = ctl_q;
  assign rd_n_next_o = ctl_d.rd_n;
  assign wdata_q_o   = wdata_q;
  assign drive_q_o   = drive_q;

endmodule

// File: rtl/rd_hold.sv
module rd_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n_q_i,
  input  logic              rd_n_next_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic [DATA_W-1:0] hold_o
);

  logic              cap_en;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] hold_d;

  always_comb begin
    cap_en = ~rd_n_q_i & rd_n_next_i;
    hold_d = cap_en ? dev_data_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/pport_ide_bridge.sv
module pport_ide_bridge
  import pport_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = PORT_W,
  parameter int unsigned ADDR_W = REG_ADDR_W,
  parameter int unsigned SYNC_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_i,
  input  logic                         hs_n_i,
  input  logic [DATA_W-1:0]            host_wdata_i,
  output logic [DATA_W-1:0]            host_rdata_o,
  output logic                         ide_cs0_n_o,
  output logic [ADDR_W-1:0]            ide_addr_o,
  output logic                         ide_rd_n_o,
  output logic                         ide_wr_n_o,
  output logic [DATA_W-1:0]            ide_data_o,
  output logic                         ide_data_oe_o,
  input  logic [DATA_W-1:0]            ide_data_i,
  output logic [DATA_W-ADDR_W-3:0]     spare_o
);

  localparam int unsigned RD_BIT  = ADDR_W;
  localparam int unsigned WR_BIT  = ADDR_W + 1;
  localparam int unsigned SPARE_L = ADDR_W + 2;

  logic [SYNC_W-1:0] rst_pipe_q;
  logic              rst_sync_n;
  logic [DATA_W-1:0] cmd_next;
  logic [DATA_W-1:0] cmd_q;
  ide_ctl_t          ctl_q;
  logic              rd_n_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_W-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_W-1];

  cmd_latch #(.DATA_W(DATA_W)) i_cmd_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sel_i      (sel_i),
    .port_i     (host_wdata_i),
    .cmd_next_o (cmd_next),
    .cmd_q_o    (cmd_q)
  );

  strobe_gen #(.DATA_W(DATA_W)) i_strobe_gen (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sel_i       (sel_i),
    .hs_n_i      (hs_n_i),
    .rd_dis_i    (cmd_next[RD_BIT]),
    .wr_dis_i    (cmd_next[WR_BIT]),
    .port_i      (host_wdata_i),
    .ctl_q_o     (ctl_q),
    .rd_n_next_o (rd_n_next),
    .wdata_q_o   (ide_data_o),
    .drive_q_o   (ide_data_oe_o)
  );

  rd_hold #(.DATA_W(DATA_W)) i_rd_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_n_q_i    (ctl_q.rd_n),
    .rd_n_next_i (rd_n_next),
    .dev_data_i  (ide_data_i),
    .hold_o      (host_rdata_o)
  );

  assign ide_cs0_n_o = ctl_q.cs_n;
  assign ide_rd_n_o  = ctl_q.rd_n;
  assign ide_wr_n_o  = ctl_q.wr_n;
  assign ide_addr_o  = cmd_q[ADDR_W-1:0];
  assign spare_o     = cmd_q[DATA_W-1:SPARE_L];

endmodule

// File: rtl/pport_ide_bridge_chk.sv
module pport_ide_bridge_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              hs_n_i,
  input logic              ide_cs0_n_o,
  input logic              ide_rd_n_o,
  input logic              ide_wr_n_o,
  input logic [ADDR_W-1:0] ide_addr_o,
  input logic [DATA_W-1:0] host_rdata_o
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  assert_cs_tracks_select_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ide_cs0_n_o == $past(sel_i));

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (!sel_i && !$past(sel_i)) |=> $stable(ide_addr_o));

  assert_wr_needs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !ide_wr_n_o |-> !$past(hs_n_i));

  assert_rd_needs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !ide_rd_n_o |-> !$past(hs_n_i));

  assert_idle_when_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(sel_i) |-> (ide_rd_n_o && ide_wr_n_o));

  assert_hold_only_on_rd_end_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !$rose(ide_rd_n_o) |-> $stable(host_rdata_o));

endmodule

bind pport_ide_bridge pport_ide_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .sel_i        (sel_i),
  .hs_n_i       (hs_n_i),
  .ide_cs0_n_o  (ide_cs0_n_o),
  .ide_rd_n_o   (ide_rd_n_o),
  .ide_wr_n_o   (ide_wr_n_o),
  .ide_addr_o   (ide_addr_o),
  .host_rdata_o (host_rdata_o)
);

// File: tb/test_pport_ide_bridge.sv
module test_pport_ide_bridge;

  logic       clk;
  logic       rst_n;
  logic       sel;
  logic       hs_n;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       cs0_n;
  logic [2:0] addr;
  logic       rd_n;
  logic       wr_n;
  logic [7:0] dev_out;
  logic       dev_oe;
  logic [7:0] dev_in;
  logic [2:0] spare;

  pport_ide_bridge i_pport_ide_bridge (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (sel),
    .hs_n_i        (hs_n),
    .host_wdata_i  (wdata),
    .host_rdata_o  (rdata),
    .ide_cs0_n_o   (cs0_n),
    .ide_addr_o    (addr),
    .ide_rd_n_o    (rd_n),
    .ide_wr_n_o    (wr_n),
    .ide_data_o    (dev_out),
    .ide_data_oe_o (dev_oe),
    .ide_data_i    (dev_in),
    .spare_o       (spare)
  );

  typedef struct packed {
    logic       is_wr;
    logic [2:0] addr;
    logic [7:0] data;
  } item_t;

  item_t exp_q[$];
  int    n_chk;
  int    n_bad;
  int    rd_done;
  logic  mon_on;
  logic  finished;

  // device model: returns {access count, register address}
  logic [4:0] dev_cnt;
  logic       dev_was_low;
  assign dev_in = {dev_cnt, addr};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      dev_cnt     <= '0;
      dev_was_low <= 1'b0;
    end else begin
      if (dev_was_low && rd_n) dev_cnt <= dev_cnt + 5'd1;
      dev_was_low <= ~rd_n;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per observed strobe
  always @(negedge clk) begin
    if (mon_on && (!rd_n || !wr_n)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected strobe", {6'd0, rd_n, wr_n}, 8'h03);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(wr_n == !it.is_wr && rd_n == it.is_wr, "R5/R6 strobe kind", {6'd0, rd_n, wr_n}, {6'd0, it.is_wr, !it.is_wr});
        chk(addr == it.addr, "R9 strobe address", {5'd0, addr}, {5'd0, it.addr});
        if (it.is_wr) begin
          chk(dev_out == it.data, "R5 write data", dev_out, it.data);
          chk(dev_oe == 1'b1, "R5 data drive", {7'd0, dev_oe}, 8'h01);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cmd(input logic [7:0] c);
    sel = 1'b1; wdata = c; cyc(1);
    sel = 1'b0; cyc(1);
    chk(addr == c[2:0], "R2 address capture", {5'd0, addr}, {5'd0, c[2:0]});
    chk(spare == c[7:5], "R2 spare capture", {5'd0, spare}, {5'd0, c[7:5]});
    chk(cs0_n == 1'b0, "R4 select low", {7'd0, cs0_n}, 8'h00);
  endtask

  task automatic put(input logic [7:0] d, input logic [2:0] a);
    exp_q.push_back('{is_wr: 1'b1, addr: a, data: d});
    wdata = d; hs_n = 1'b0; cyc(1);
    hs_n = 1'b1; cyc(1);
    chk(wr_n == 1'b1, "R5 one-cycle write strobe", {7'd0, wr_n}, 8'h01);
  endtask

  task automatic get(input logic [2:0] a, input logic end_sel);
    logic [7:0] e;
    e = {rd_done[4:0], a};
    exp_q.push_back('{is_wr: 1'b0, addr: a, data: 8'h00});
    hs_n = 1'b0; cyc(1);
    hs_n = 1'b1;
    if (end_sel) sel = 1'b1;
    cyc(1);
    rd_done++;
    chk(rd_n == 1'b1, "R6 one-cycle read strobe", {7'd0, rd_n}, 8'h01);
    chk(rdata == e, "R8 holding register", rdata, e);
    cyc(1);
    chk(rdata == e, "R8 hold stable", rdata, e);
  endtask

  initial begin
    finished = 1'b0;
    n_chk = 0; n_bad = 0; rd_done = 0; mon_on = 1'b0;
    rst_n = 1'b0; sel = 1'b1; hs_n = 1'b1; wdata = 8'h00;
    cyc(3);
    chk(rd_n && wr_n && cs0_n, "R1 strobes in reset", {5'd0, cs0_n, rd_n, wr_n}, 8'h07);
    rst_n = 1'b1;
    cyc(4);
    mon_on = 1'b1;
    chk(rd_n && wr_n && cs0_n, "R1 strobes idle", {5'd0, cs0_n, rd_n, wr_n}, 8'h07);
    chk(addr == 3'b111, "R1 address", {5'd0, addr}, 8'h07);
    chk(spare == 3'b111, "R1 spare", {5'd0, spare}, 8'h07);
    chk(rdata == 8'h00, "R1 holding register", rdata, 8'h00);

    // single write, addr 2, spare 111
    load_cmd(8'hEA);
    put(8'h5A, 3'd2);
    // R3: port changes while selected do not touch the latch
    wdata = 8'h00; cyc(2);
    chk(addr == 3'd2 && spare == 3'b111, "R3 latch held", {2'd0, spare, addr}, 8'h3A);
    put(8'h00, 3'd2);
    chk(rd_n == 1'b1, "R3 read still disabled", {7'd0, rd_n}, 8'h01);

    // R7: pulses while deselected
    sel = 1'b1; cyc(1);
    chk(cs0_n == 1'b1, "R4 select high", {7'd0, cs0_n}, 8'h01);
    wdata = 8'hE0;
    for (int i = 0; i < 3; i++) begin
      hs_n = 1'b0; cyc(1);
      chk(rd_n && wr_n, "R7 no strobe while deselected", {6'd0, rd_n, wr_n}, 8'h03);
      hs_n = 1'b1; cyc(1);
    end

    // R9: write burst to data register
    load_cmd(8'hE8);
    for (int i = 0; i < 4; i++) begin
      put(8'h10 + 8'(i), 3'd0);
      cyc(i);
    end

    // read burst, addr 3, spare 000; last access ends as select rises
    load_cmd(8'h13);
    get(3'd3, 1'b0);
    get(3'd3, 1'b0);
    get(3'd3, 1'b1);
    chk(cs0_n == 1'b1, "R8 select raised at burst end", {7'd0, cs0_n}, 8'h01);

    // R10: write pulse in the same cycle select falls
    sel = 1'b1; wdata = 8'hED; cyc(1);
    exp_q.push_back('{is_wr: 1'b1, addr: 3'd5, data: 8'hED});
    sel = 1'b0; hs_n = 1'b0; cyc(1);
    hs_n = 1'b1; cyc(1);
    chk(addr == 3'd5, "R10 write gated by new byte", {5'd0, addr}, 8'h05);

    // R10: read pulse in the same cycle select falls
    sel = 1'b1; wdata = 8'hF4; cyc(1);
    begin
      logic [7:0] e;
      e = {rd_done[4:0], 3'd4};
      exp_q.push_back('{is_wr: 1'b0, addr: 3'd4, data: 8'h00});
      sel = 1'b0; hs_n = 1'b0; cyc(1);
      hs_n = 1'b1; cyc(1);
      rd_done++;
      chk(rdata == e, "R10 read gated by new byte", rdata, e);
    end

    sel = 1'b1; cyc(3);
    chk(exp_q.size() == 0, "R9 all expected strobes seen", 8'(exp_q.size()), 8'h00);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule